// File: doc/BRIEF.md
# Interleaved YCbCr Video Input Demultiplexer

This block sits at the pixel input of a video encoder. It takes component video in one of several bus styles and turns it into a single system-clock stream. Each output word carries one luma sample, the chroma sample that belongs with it, a flag that says whether that chroma is Cr or Cb, and a valid strobe. A 3-bit mode field selects the bus style. The styles are:

- one 8-bit bus with one sample per rising edge;
- two 8-bit buses, one for luma and one for chroma;
- one 8-bit bus sampled on both clock edges. A swap bit chooses which edge carries chroma.

In every style the block also watches for embedded timing reference codes. A code is an all-ones sample, two zero samples, then a status word. The block reports start-of-line and end-of-line events as single-cycle pulses. It holds the field and vertical-blanking bits from the most recent code. Code samples are never passed on as pixels.

Inputs are captured on the rising edge, and in the dual-edge style also on the falling edge. The falling-edge register is brought onto the rising edge before any decision uses it. The status-word bit positions, counted from the MSB, are: bit DW-2 is field, bit DW-3 is vertical blanking, and bit DW-4 is H.

Top module: `ycc_input_demux`

## Requirements
- R1: After reset, outValid, savPulse, eavPulse, fieldFlag and vblankFlag are 0. The mode register holds 3'b111 (8-bit interleaved, one sample per rising edge), so that style works with no mode load.
- R2: When modeLoad is high at a rising edge, modeIn is stored as the mode. The codes 3'b011, 3'b101 and 3'b110 are undefined. Under an undefined code the block raises neither outValid nor savPulse nor eavPulse, whatever data arrives.
- R3: In modes 3'b000 and 3'b111, pixLo is taken once per rising edge in the repeating order Cb, Y, Cr, Y. One word is output per Y sample, with C equal to the chroma sample just before that Y. outIsCr is 0 after Cb and 1 after Cr. The word appears two rising edges after the Y sample is captured.
- R4: In modes 3'b001 and 3'b010, each rising edge outputs Y from pixLo and C from pixHi of the same edge. outIsCr alternates from word to word and starts at 0 (Cb).
- R5: In mode 3'b100, pixLo is captured on the rising edge and again on the following falling edge. Each such pair yields one output word, and outIsCr alternates from word to word starting at 0.
- R6: In mode 3'b100 with edgeSwap = 0, the rising-edge sample is chroma and the falling-edge sample is luma. With edgeSwap = 1 the roles are exchanged.
- R7: A sample sequence of all ones, zero, zero and a status word is a timing code. Status bit H = 0 gives a one-cycle savPulse and H = 1 gives a one-cycle eavPulse, two rising edges after the status word is captured. fieldFlag and vblankFlag load the field and vertical-blanking bits of the status word and hold them until the next code.
- R8: The four samples of a timing code never produce an output word, and no output word is valid in the same cycle as savPulse or eavPulse.
- R9: After a start-of-line code, the next sample is treated as Cb in the 8-bit modes, and the Cr/Cb alternation restarts at Cb in the other modes. This holds whatever the component phase was before the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; the dual-edge style also uses its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| modeLoad | input | 1 | Stores modeIn as the input mode |
| modeIn | input | 3 | Input-mode code |
| edgeSwap | input | 1 | Dual-edge style: 1 puts luma on the rising edge |
| pixLo | input | DW | Shared bus, or the luma bus in the two-bus modes |
| pixHi | input | DW | Chroma bus in the two-bus modes |
| outY | output | DW | Luma sample of the current output word |
| outC | output | DW | Chroma sample paired with outY |
| outIsCr | output | 1 | 1 when outC is Cr, 0 when Cb |
| outValid | output | 1 | Output word valid this cycle |
| savPulse | output | 1 | One-cycle start-of-active-video event |
| eavPulse | output | 1 | One-cycle end-of-active-video event |
| fieldFlag | output | 1 | Field bit from the last timing code |
| vblankFlag | output | 1 | Vertical-blanking bit from the last timing code |

## Verification
The hardest case to reach is a start-of-line code that arrives while the four-phase component counter is out of step. In a clean stream the counter already points at Cb after a code, so a realignment bug would never show. The stimulus inserts one extra chroma sample ahead of the code, which leaves the counter one phase off. It then checks that the first word after the code pairs the new Y with the chroma sample that follows the code. In the dual-edge style, the falling-edge register is checked under both settings of the swap bit, with luma and chroma given distinct values so that any lane exchange shows up.

// File: rtl/ycc_demux_pkg.sv
package ycc_demux_pkg;

  localparam logic [2:0] MODE_SD_MUX    = 3'b000;
  localparam logic [2:0] MODE_PROG_WIDE = 3'b001;
  localparam logic [2:0] MODE_HD_WIDE   = 3'b010;
  localparam logic [2:0] MODE_PROG_DDR  = 3'b100;
  localparam logic [2:0] MODE_PROG_2X   = 3'b111;

  // How samples reach the control each rising edge
  typedef enum logic [1:0] {
    LANE_NONE,
    LANE_SINGLE,
    LANE_WIDE,
    LANE_PAIR
  } lane_e;

  // Source of the chroma sample in an output word
  typedef enum logic [1:0] {
    CSEL_HOLD,
    CSEL_BUS,
    CSEL_A,
    CSEL_B
  } csel_e;

  typedef struct packed {
    logic  holdChroma;
    logic  emit;
    logic  isCr;
    logic  lumaFromB;
    csel_e chromaSel;
  } strobe_t;

  function automatic lane_e laneOf(input logic [2:0] mode);
    lane_e lane;
    case (mode)
      MODE_SD_MUX, MODE_PROG_2X:     lane = LANE_SINGLE;
      MODE_PROG_WIDE, MODE_HD_WIDE:  lane = LANE_WIDE;
      MODE_PROG_DDR:                 lane = LANE_PAIR;
      default:                       lane = LANE_NONE;
    endcase
    return lane;
  endfunction

endpackage

// File: rtl/ycc_demux_datapath.sv
module ycc_demux_datapath
  import ycc_demux_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] pixLo,
  input  logic [DW-1:0] pixHi,
  input  strobe_t       strobe,
  output logic [DW-1:0] sampA,
  output logic [DW-1:0] sampB,
  output logic          sampLive,
  output logic [DW-1:0] outY,
  output logic [DW-1:0] outC,
  output logic          outIsCr,
  output logic          outValid
);

  logic [DW-1:0] riseLo, riseHi, fallLo, sampC, chromaHold, chromaPick, lumaPick;
  logic [1:0]    fillSr;

  // Falling-edge capture for the dual-edge style
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallLo <= '0;
    else       fallLo <= pixLo;
  end

  // Rising-edge capture, then retime: sampA/sampB form one time-ordered pair
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseLo <= '0;
      riseHi <= '0;
      sampA  <= '0;
      sampB  <= '0;
      sampC  <= '0;
      fillSr <= '0;
    end else begin
      riseLo <= pixLo;
      riseHi <= pixHi;
      sampA  <= riseLo;
      sampB  <= fallLo;
      sampC  <= riseHi;
      fillSr <= {fillSr[0], 1'b1};
    end
  end

  assign sampLive = fillSr[1];

  always_comb begin
    case (strobe.chromaSel)
      CSEL_HOLD: chromaPick = chromaHold;
      CSEL_BUS:  chromaPick = sampC;
      CSEL_A:    chromaPick = sampA;
      default:   chromaPick = sampB;
    endcase
    lumaPick = strobe.lumaFromB ? sampB : sampA;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chromaHold <= '0;
      outY       <= '0;
      outC       <= '0;
      outIsCr    <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      if (strobe.holdChroma) chromaHold <= sampA;
      outValid <= strobe.emit;
      if (strobe.emit) begin
        outY    <= lumaPick;
        outC    <= chromaPick;
        outIsCr <= strobe.isCr;
      end
    end
  end

endmodule

// File: rtl/ycc_demux_ctrl.sv
module ycc_demux_ctrl
  import ycc_demux_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          modeLoad,
  input  logic [2:0]    modeIn,
  input  logic          edgeSwap,
  input  logic [DW-1:0] sampA,
  input  logic [DW-1:0] sampB,
  input  logic          sampLive,
  output strobe_t       strobe,
  output logic          savPulse,
  output logic          eavPulse,
  output logic          fieldFlag,
  output logic          vblankFlag
);

  localparam logic [DW-1:0] CODE_ONES = '1;
  localparam logic [DW-1:0] CODE_ZERO = '0;
  localparam int F_POS = DW - 2;
  localparam int V_POS = DW - 3;
  localparam int H_POS = DW - 4;

  logic [2:0]    modeReg;
  lane_e         lane;
  logic [DW-1:0] hist1, hist2, hist3, histB;
  logic [1:0]    codeLeft, phase;
  logic          crToggle;
  logic          active, isLead, suppress, trsHit, trsF, trsV, trsH;

  assign lane     = laneOf(modeReg);
  assign active   = sampLive && (lane != LANE_NONE);
  assign isLead   = active && (sampA == CODE_ONES) && (codeLeft == 2'd0);
  assign suppress = isLead || (codeLeft != 2'd0);

  // Timing-code recognition on the time-ordered sample history
  always_comb begin
    trsHit = 1'b0;
    if (active) begin
      if (lane == LANE_PAIR)
        trsHit = (hist1 == CODE_ONES) && (histB == CODE_ZERO) && (sampA == CODE_ZERO);
      else
        trsHit = (hist3 == CODE_ONES) && (hist2 == CODE_ZERO) && (hist1 == CODE_ZERO);
    end
    trsF = (lane == LANE_PAIR) ? sampB[F_POS] : sampA[F_POS];
    trsV = (lane == LANE_PAIR) ? sampB[V_POS] : sampA[V_POS];
    trsH = (lane == LANE_PAIR) ? sampB[H_POS] : sampA[H_POS];
  end

  // Strobes toward the datapath
  always_comb begin
    strobe = '0;
    strobe.chromaSel = CSEL_HOLD;
    if (active && !suppress) begin
      case (lane)
        LANE_SINGLE: begin
          if (!phase[0]) strobe.holdChroma = 1'b1;
          else begin
            strobe.emit = 1'b1;
            strobe.isCr = phase[1];
          end
        end
        LANE_WIDE: begin
          strobe.emit      = 1'b1;
          strobe.isCr      = crToggle;
          strobe.chromaSel = CSEL_BUS;
        end
        default: begin
          strobe.emit      = 1'b1;
          strobe.isCr      = crToggle;
          strobe.lumaFromB = !edgeSwap;
          strobe.chromaSel = edgeSwap ? CSEL_B : CSEL_A;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg    <= MODE_PROG_2X;
      hist1      <= '0;
      hist2      <= '0;
      hist3      <= '0;
      histB      <= '0;
      codeLeft   <= '0;
      phase      <= '0;
      crToggle   <= 1'b0;
      savPulse   <= 1'b0;
      eavPulse   <= 1'b0;
      fieldFlag  <= 1'b0;
      vblankFlag <= 1'b0;
    end else begin
      if (modeLoad) modeReg <= modeIn;
      if (sampLive) begin
        hist1 <= sampA;
        hist2 <= hist1;
        hist3 <= hist2;
        histB <= sampB;
      end
      if (!active)                codeLeft <= 2'd0;
      else if (isLead)            codeLeft <= (lane == LANE_PAIR) ? 2'd1 : 2'd3;
      else if (codeLeft != 2'd0)  codeLeft <= codeLeft - 2'd1;

      if (trsHit && !trsH) begin
        phase    <= 2'd0;
        crToggle <= 1'b0;
      end else if (active && !suppress) begin
        if (lane == LANE_SINGLE) phase <= phase + 2'd1;
        else                     crToggle <= !crToggle;
      end

      savPulse <= trsHit && !trsH;
      eavPulse <= trsHit && trsH;
      if (trsHit) begin
        fieldFlag  <= trsF;
        vblankFlag <= trsV;
      end
    end
  end

  // The status word always lands in the last slot of the suppression window
  assert_code_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    trsHit |-> (codeLeft == 2'd1));

  assert_sav_eav_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(savPulse && eavPulse));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    (savPulse || eavPulse) |=> !(savPulse || eavPulse));

  assert_phase_realign_R9: assert property (@(posedge clk) disable iff (!rstN)
    savPulse |-> (phase == 2'd0 && !crToggle));

endmodule

// File: rtl/ycc_input_demux.sv
module ycc_input_demux
  import ycc_demux_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          modeLoad,
  input  logic [2:0]    modeIn,
  input  logic          edgeSwap,
  input  logic [DW-1:0] pixLo,
  input  logic [DW-1:0] pixHi,
  output logic [DW-1:0] outY,
  output logic [DW-1:0] outC,
  output logic          outIsCr,
  output logic          outValid,
  output logic          savPulse,
  output logic          eavPulse,
  output logic          fieldFlag,
  output logic          vblankFlag
);

  strobe_t       strobe;
  logic [DW-1:0] sampA, sampB;
  logic          sampLive;

  ycc_demux_datapath #(.DW(DW)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .pixLo    (pixLo),
    .pixHi    (pixHi),
    .strobe   (strobe),
    .sampA    (sampA),
    .sampB    (sampB),
    .sampLive (sampLive),
    .outY     (outY),
    .outC     (outC),
    .outIsCr  (outIsCr),
    .outValid (outValid)
  );

  ycc_demux_ctrl #(.DW(DW)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeLoad   (modeLoad),
    .modeIn     (modeIn),
    .edgeSwap   (edgeSwap),
    .sampA      (sampA),
    .sampB      (sampB),
    .sampLive   (sampLive),
    .strobe     (strobe),
    .savPulse   (savPulse),
    .eavPulse   (eavPulse),
    .fieldFlag  (fieldFlag),
    .vblankFlag (vblankFlag)
  );

  assert_no_pixel_on_trs_R8: assert property (@(posedge clk) disable iff (!rstN)
    (savPulse || eavPulse) |-> !outValid);

endmodule

// File: tb/sim_ycc_input_demux.sv
`timescale 1ns/1ps
module sim_ycc_input_demux;

  logic       clk = 1'b0;
  logic       rstN, modeLoad, edgeSwap;
  logic [2:0] modeIn;
  logic [7:0] pixLo, pixHi, outY, outC;
  logic       outIsCr, outValid, savPulse, eavPulse, fieldFlag, vblankFlag;

  always #4 clk = ~clk;

  ycc_input_demux #(.DW(8)) u0 (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeIn(modeIn), .edgeSwap(edgeSwap),
    .pixLo(pixLo), .pixHi(pixHi), .outY(outY), .outC(outC), .outIsCr(outIsCr),
    .outValid(outValid), .savPulse(savPulse), .eavPulse(eavPulse),
    .fieldFlag(fieldFlag), .vblankFlag(vblankFlag)
  );

  int checks = 0;
  int fails  = 0;

  // Output capture log
  logic [7:0] capY [256];
  logic [7:0] capC [256];
  logic       capCr[256];
  int ncap = 0, savCount = 0, eavCount = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (outValid && ncap < 256) begin
        capY[ncap]  = outY;
        capC[ncap]  = outC;
        capCr[ncap] = outIsCr;
        ncap++;
      end
      if (savPulse) savCount++;
      if (eavPulse) eavCount++;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Rising-edge sample a (with c on pixHi), falling-edge sample b
  task automatic push(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    pixLo = a;
    pixHi = c;
    @(posedge clk);
    #1 pixLo = b;
    @(negedge clk);
    #1;
  endtask

  task automatic push1(input logic [7:0] a);
    push(a, a, 8'h00);
  endtask

  // Start-of-line code (status 8'h80) in the lane layout of the mode
  task automatic flushSav(input bit dual);
    if (dual) begin
      push(8'hFF, 8'h00, 8'h00);
      push(8'h00, 8'h80, 8'h00);
    end else begin
      push1(8'hFF); push1(8'h00); push1(8'h00); push1(8'h80);
    end
  endtask

  task automatic setMode(input logic [2:0] m);
    modeIn   = m;
    modeLoad = 1'b1;
    @(posedge clk);
    #1 modeLoad = 1'b0;
    @(negedge clk);
    #1;
  endtask

  task automatic expectCap(input string req, input int idx, input logic [7:0] y,
                           input logic [7:0] c, input logic cr);
    check(req, $sformatf("word %0d {Y,C,isCr}", idx), {15'd0, capY[idx], capC[idx], capCr[idx]},
          {15'd0, y, c, cr});
  endtask

  // {sample, expValid, expY, expC, expCr, expSav, expEav}: outputs seen after pushing the sample
  localparam int NV = 19;
  localparam logic [27:0] VEC [NV] = '{
    {8'h10, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h20, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h30, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h40, 1'b1, 8'h20, 8'h10, 1'b0, 1'b0, 1'b0},
    {8'h45, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'hFF, 1'b1, 8'h40, 8'h30, 1'b1, 1'b0, 1'b0},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h80, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h50, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h60, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0},
    {8'h70, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h61, 1'b1, 8'h60, 8'h50, 1'b0, 1'b0, 1'b0},
    {8'hFF, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h00, 1'b1, 8'h61, 8'h70, 1'b1, 1'b0, 1'b0},
    {8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'hB0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h22, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h22, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base;
    int baseSav;
    rstN = 1'b0; modeLoad = 1'b0; modeIn = 3'b000; edgeSwap = 1'b0;
    pixLo = 8'h00; pixHi = 8'h00;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    check("R1", "outValid", {31'd0, outValid}, 32'd0);
    check("R1", "sav/eav", {30'd0, savPulse, eavPulse}, 32'd0);
    check("R1", "field/vblank", {30'd0, fieldFlag, vblankFlag}, 32'd0);

    // R1 default mode (no load), R3 ordering, R7 codes, R8 suppression, R9 realign after stray Cb 8'h45
    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      logic [19:0] act;
      v = VEC[i];
      push1(v[27:20]);
      act = {outValid, outValid ? outY : 8'h00, outValid ? outC : 8'h00,
             outValid ? outIsCr : 1'b0, savPulse, eavPulse};
      check("R3/R7/R8/R9", $sformatf("vector %0d", i), {12'd0, act}, {12'd0, v[19:0]});
    end
    check("R7", "flags after end code 8'hB0", {30'd0, fieldFlag, vblankFlag}, {30'd0, 1'b0, 1'b1});

    // R7: start code with field=1, vblank=0
    push1(8'hFF); push1(8'h00); push1(8'h00); push1(8'hC0);
    push1(8'h80); push1(8'h80);
    check("R7", "sav pulse for 8'hC0", {30'd0, savPulse, eavPulse}, {30'd0, 1'b1, 1'b0});
    check("R7", "flags after 8'hC0", {30'd0, fieldFlag, vblankFlag}, {30'd0, 1'b1, 1'b0});

    // R3: standard-definition 8-bit mode
    setMode(3'b000);
    flushSav(1'b0);
    base = ncap;
    push1(8'h15); push1(8'h25); push1(8'h35); push1(8'h45);
    flushSav(1'b0);
    check("R3", "mode 000 word count", ncap - base, 32'd2);
    expectCap("R3", base,     8'h25, 8'h15, 1'b0);
    expectCap("R3", base + 1, 8'h45, 8'h35, 1'b1);

    // R4: two-bus modes
    for (int m = 1; m <= 2; m++) begin
      setMode(m[2:0]);
      flushSav(1'b0);
      base = ncap;
      for (int k = 0; k < 4; k++) push(8'h11 + k[7:0], 8'h11 + k[7:0], 8'hA1 + k[7:0]);
      flushSav(1'b0);
      check("R4", $sformatf("mode %0d word count", m), ncap - base, 32'd4);
      for (int k = 0; k < 4; k++)
        expectCap("R4", base + k, 8'h11 + k[7:0], 8'hA1 + k[7:0], k[0]);
    end

    // R5/R6: dual-edge, chroma on rising edge
    edgeSwap = 1'b0;
    setMode(3'b100);
    flushSav(1'b1);
    base = ncap;
    push(8'h31, 8'h41, 8'h00); push(8'h32, 8'h42, 8'h00); push(8'h33, 8'h43, 8'h00);
    flushSav(1'b1);
    check("R5", "dual-edge word count", ncap - base, 32'd3);
    expectCap("R6", base,     8'h41, 8'h31, 1'b0);
    expectCap("R6", base + 1, 8'h42, 8'h32, 1'b1);
    expectCap("R5", base + 2, 8'h43, 8'h33, 1'b0);

    // R6: dual-edge, luma on rising edge
    edgeSwap = 1'b1;
    flushSav(1'b1);
    base = ncap;
    push(8'h51, 8'h61, 8'h00); push(8'h52, 8'h62, 8'h00);
    flushSav(1'b1);
    check("R6", "swapped word count", ncap - base, 32'd2);
    expectCap("R6", base,     8'h51, 8'h61, 1'b0);
    expectCap("R6", base + 1, 8'h52, 8'h62, 1'b1);

    // R2: undefined mode produces nothing
    setMode(3'b011);
    base = ncap;
    baseSav = savCount;
    push1(8'h10); push1(8'h20); push1(8'h30); push1(8'h40);
    push1(8'hFF); push1(8'h00); push1(8'h00); push1(8'h80);
    push1(8'h10); push1(8'h10);
    check("R2", "words under mode 011", ncap - base, 32'd0);
    check("R2", "sav events under mode 011", savCount - baseSav, 32'd0);
    check("R2", "outValid port under mode 011", {31'd0, outValid}, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule